// File: doc/BRIEF.md
# Acquisition Scan-List Sequencer

This block is the front end of a multiplexed analog-to-digital converter. Software describes each channel it wants sampled with four 16-bit control words and hands them over one byte at a time through a scan-list port. The bytes are paired into words, buffered, and moved into a configuration pipe only while loading is switched on. Once the pipe holds a complete scan, each tick of a programmable divider runs that scan. The block steps through the stored channels in order, starts one conversion per channel, and puts each returned sample into a results FIFO that software reads.

Control writes carry either a command code or a set of reset bits. A combinational status word reports the state of the results FIFO, the scan, the pipe, the scan-list buffer and the pacer. The converter itself is outside the block. It sees a one-cycle start pulse together with the channel fields, and after some latency it returns a valid strobe with the data.

Top module: `acq_seq`

## Requirements
- R1: After reset, `status` reads 0x0020 (only the scan-list-empty flag is set), no results are held, and `conv_start` is low.
- R2: Register selects on `wr_addr` are 0 for control, 1 for scan-list byte, 2 for divider low and 3 for divider high. Each scan-list word takes two byte writes (`wr_data[7:0]`): the first supplies bits [7:0] and the second supplies bits [15:8].
- R3: A channel descriptor is four consecutive words. Words move into the pipe only after control 0x0011 and stop moving after 0x0010. Status bit 4 (pipe full) sets when a descriptor whose word 1 bit 2 (end of scan) is set has loaded, or when all pipe slots are used. Status bit 5 is set while the scan-list word buffer is empty.
- R4: A control write with `wr_data[15:4]` zero is a reset request. Bit 2 clears the scan-list buffer and its byte pairing, bit 1 clears the results FIFO, and bit 0 clears the configuration pipe and aborts any scan.
- R5: Control 0x0031 starts the pacer and 0x0030 stops it. The divider is 48 bits: divider low supplies bits [31:0] and divider high supplies bits [47:32]. Ticks come every divider-value cycles, and a divider of 0 behaves as 1.
- R6: A tick that arrives while the pipe is full and no scan is running starts a scan. The scan issues one `conv_start` pulse per descriptor, in load order, and waits for `adc_valid` before moving on. It ends after the end-of-scan descriptor or the last loaded descriptor. Status bit 3 is high throughout the scan.
- R7: Each `adc_valid` during a scan pushes `adc_data` into the results FIFO. `rd_data` shows the oldest entry and `rd_en` removes it. Status bit 1 means at least one entry is held, and bit 0 means more than one.
- R8: A result that arrives while the results FIFO is full is dropped and sets status bit 2. That bit stays set until the results FIFO is reset.
- R9: A tick that arrives while a scan is running sets status bit 8 (pacer overrun). The bit stays set until the configuration pipe is reset.
- R10: With each `conv_start`, `conv_sel` is {word3[2:0], word2[7:6]}, `conv_settle` is word1 bit 1 and `conv_hold` is word1 bit 3, all taken from the descriptor being converted.
- R11: A tick that arrives while the pipe is not full starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Pop the oldest result |
| rd_data | output | 16 | Oldest result |
| status | output | 16 | Status flags |
| conv_start | output | 1 | One-cycle conversion start |
| conv_sel | output | 5 | Channel selection for the conversion |
| conv_settle | output | 1 | Long settling requested |
| conv_hold | output | 1 | Simultaneous sample-and-hold requested |
| adc_valid | input | 1 | Conversion result strobe |
| adc_data | input | 16 | Conversion result |

## Verification
The pacer overrun is the hardest condition to provoke, because it needs a tick to land while a scan is still running. The bench gets there by loading a pipe that is full by capacity, with no end-of-scan mark, and then setting a divider shorter than one four-channel scan. The same run overfills the results FIFO, so the bench can check both sticky flags and the reset that clears each of them. The main sweep varies the channel count and the selection pattern, and it predicts every converter request and every stored sample arithmetically.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_SLIST = 2'd1;
    localparam logic [1:0] REG_DIVLO = 2'd2;
    localparam logic [1:0] REG_DIVHI = 2'd3;

    localparam logic [15:0] CMD_LOAD_ON  = 16'h0011;
    localparam logic [15:0] CMD_LOAD_OFF = 16'h0010;
    localparam logic [15:0] CMD_PACE_ON  = 16'h0031;
    localparam logic [15:0] CMD_PACE_OFF = 16'h0030;

    localparam int ST_RES_MULTI = 0;
    localparam int ST_RES_DATA  = 1;
    localparam int ST_RES_OVR   = 2;
    localparam int ST_SCANNING  = 3;
    localparam int ST_PIPE_FULL = 4;
    localparam int ST_SL_EMPTY  = 5;
    localparam int ST_PACE_OVR  = 8;

    typedef struct packed {
        logic       last;
        logic       settle;
        logic       hold;
        logic [4:0] sel;
    } chan_desc_t;

    typedef enum logic [1:0] {SC_IDLE, SC_ISSUE, SC_WAIT} scan_st_e;

    function automatic chan_desc_t desc_pack(input logic [15:0] w1,
                                             input logic [15:0] w2,
                                             input logic [15:0] w3);
        chan_desc_t d;
        d.last   = w1[2];
        d.settle = w1[1];
        d.hold   = w1[3];
        d.sel    = {w3[2:0], w2[7:6]};
        return d;
    endfunction

endpackage

// File: rtl/acq_sync_fifo.sv
module acq_sync_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr) |=> (cnt == $past(cnt))); // R8

endmodule

// File: rtl/acq_pacer.sv
module acq_pacer #(
    parameter int DIV_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
    assign tick = en && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !en)       cnt <= '0;
        else if (cnt >= lim)  cnt <= '0;
        else                  cnt <= cnt + DIV_W'(1);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && lim != '0) |=> (!tick || div != $past(div))); // R5

endmodule

// File: rtl/acq_cfg_pipe.sv
module acq_cfg_pipe
    import acq_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      load_en,
    input  logic                      in_valid,
    input  logic [15:0]               in_word,
    output logic                      in_ready,
    output logic                      full,
    output logic [$clog2(SLOTS):0]    nd,
    input  logic [$clog2(SLOTS)-1:0]  rd_idx,
    output chan_desc_t                rd_desc
);
    localparam int IW = $clog2(SLOTS);
    localparam logic [IW:0] LAST_SLOT = (IW+1)'(SLOTS-1);

    chan_desc_t  slot_q [SLOTS];
    logic [1:0]  wsel;
    logic [15:0] h1, h2;
    logic [IW:0] nd_q;
    logic        full_q;
    logic        accept, fin;
    chan_desc_t  new_d;
    logic        unused_in;

    assign in_ready  = load_en && !full_q;
    assign accept    = in_valid && in_ready;
    assign fin       = accept && (wsel == 2'd3);
    assign new_d     = desc_pack(h1, h2, in_word);
    assign full      = full_q;
    assign nd        = nd_q;
    assign rd_desc   = slot_q[rd_idx];
    assign unused_in = ^in_word;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wsel   <= '0;
            nd_q   <= '0;
            full_q <= 1'b0;
            h1     <= '0;
            h2     <= '0;
        end else if (accept) begin
            wsel <= wsel + 2'd1;
            if (wsel == 2'd1) h1 <= in_word;
            if (wsel == 2'd2) h2 <= in_word;
            if (fin) begin
                nd_q   <= nd_q + 1'b1;
                full_q <= new_d.last || (nd_q == LAST_SLOT);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fin) slot_q[nd_q[IW-1:0]] <= new_d;
    end

    AST_FULL_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> (nd_q == $past(nd_q))); // R3

endmodule

// File: rtl/acq_seq.sv
module acq_seq
    import acq_pkg::*;
#(
    parameter int PIPE_SLOTS = 4,
    parameter int SL_DEPTH   = 16,
    parameter int RES_DEPTH  = 4,
    parameter int DIVLO_W    = 32,
    parameter int DIVHI_W    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    output logic [15:0] status,
    output logic        conv_start,
    output logic [4:0]  conv_sel,
    output logic        conv_settle,
    output logic        conv_hold,
    input  logic        adc_valid,
    input  logic [15:0] adc_data
);
    localparam int DIV_W = DIVLO_W + DIVHI_W;
    localparam int PW    = $clog2(PIPE_SLOTS);
    localparam int RCW   = $clog2(RES_DEPTH) + 1;
    localparam int SCW   = $clog2(SL_DEPTH) + 1;
    localparam logic [PW:0]    ONE_P = (PW+1)'(1);
    localparam logic [RCW-1:0] ONE_R = RCW'(1);

    // register write decode
    logic is_ctrl, is_reset_req, rst_sl, rst_res, rst_pipe, slist_wr;
    assign is_ctrl      = wr_en && (wr_addr == REG_CTRL);
    assign is_reset_req = is_ctrl && (wr_data[15:4] == '0);
    assign rst_sl       = is_reset_req && wr_data[2];
    assign rst_res      = is_reset_req && wr_data[1];
    assign rst_pipe     = is_reset_req && wr_data[0];
    assign slist_wr     = wr_en && (wr_addr == REG_SLIST);

    logic               load_en, pace_en;
    logic [DIVLO_W-1:0] div_lo;
    logic [DIVHI_W-1:0] div_hi;
    logic [7:0]         lo_byte;
    logic               lo_have;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_en <= 1'b0;
            pace_en <= 1'b0;
            div_lo  <= '0;
            div_hi  <= '0;
            lo_byte <= '0;
            lo_have <= 1'b0;
        end else begin
            if (is_ctrl) begin
                case (wr_data[15:0])
                    CMD_LOAD_ON:  load_en <= 1'b1;
                    CMD_LOAD_OFF: load_en <= 1'b0;
                    CMD_PACE_ON:  pace_en <= 1'b1;
                    CMD_PACE_OFF: pace_en <= 1'b0;
                    default: ;
                endcase
            end
            if (wr_en && wr_addr == REG_DIVLO) div_lo <= wr_data[DIVLO_W-1:0];
            if (wr_en && wr_addr == REG_DIVHI) div_hi <= wr_data[DIVHI_W-1:0];
            if (rst_sl) begin
                lo_have <= 1'b0;
            end else if (slist_wr) begin
                lo_have <= !lo_have;
                if (!lo_have) lo_byte <= wr_data[7:0];
            end
        end
    end

    // scan-list word buffer
    logic [15:0]    sl_dout;
    logic [SCW-1:0] sl_count;
    logic           sl_full, sl_empty, pipe_ready;

    acq_sync_fifo #(.W(16), .DEPTH(SL_DEPTH)) u_sl_fifo (
        .clk(clk), .rst(rst), .clr(rst_sl),
        .push(slist_wr && lo_have), .din({wr_data[7:0], lo_byte}),
        .pop(pipe_ready), .dout(sl_dout), .count(sl_count),
        .full(sl_full), .empty(sl_empty)
    );

    // configuration pipe
    logic          pipe_full;
    logic [PW:0]   pipe_nd;
    logic [PW-1:0] idx;
    chan_desc_t    cur;

    acq_cfg_pipe #(.SLOTS(PIPE_SLOTS)) u_pipe (
        .clk(clk), .rst(rst), .clr(rst_pipe), .load_en(load_en),
        .in_valid(!sl_empty), .in_word(sl_dout), .in_ready(pipe_ready),
        .full(pipe_full), .nd(pipe_nd), .rd_idx(idx), .rd_desc(cur)
    );

    // pacer
    logic tick;
    acq_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk(clk), .rst(rst), .en(pace_en), .div({div_hi, div_lo}), .tick(tick)
    );

    // scan engine
    scan_st_e state;
    logic     pace_ovr, is_final;

    assign is_final = cur.last || (({1'b0, idx} + ONE_P) == pipe_nd);

    always_ff @(posedge clk) begin
        if (rst || rst_pipe) begin
            state <= SC_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                SC_IDLE: if (tick && pipe_full) begin
                    state <= SC_ISSUE;
                    idx   <= '0;
                end
                SC_ISSUE: state <= SC_WAIT;
                SC_WAIT: if (adc_valid) begin
                    if (is_final) begin
                        state <= SC_IDLE;
                    end else begin
                        state <= SC_ISSUE;
                        idx   <= idx + 1'b1;
                    end
                end
                default: state <= SC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rst_pipe)                 pace_ovr <= 1'b0;
        else if (tick && state != SC_IDLE)   pace_ovr <= 1'b1;
    end

    assign conv_start  = (state == SC_ISSUE);
    assign conv_sel    = cur.sel;
    assign conv_settle = cur.settle;
    assign conv_hold   = cur.hold;

    // results FIFO
    logic           res_push, res_full, res_empty, res_ovr;
    logic [RCW-1:0] res_count;
    assign res_push = (state == SC_WAIT) && adc_valid;

    acq_sync_fifo #(.W(16), .DEPTH(RES_DEPTH)) u_res_fifo (
        .clk(clk), .rst(rst), .clr(rst_res),
        .push(res_push), .din(adc_data), .pop(rd_en), .dout(rd_data),
        .count(res_count), .full(res_full), .empty(res_empty)
    );

    always_ff @(posedge clk) begin
        if (rst || rst_res)             res_ovr <= 1'b0;
        else if (res_push && res_full)  res_ovr <= 1'b1;
    end

    always_comb begin
        status               = '0;
        status[ST_RES_MULTI] = (res_count > ONE_R);
        status[ST_RES_DATA]  = !res_empty;
        status[ST_RES_OVR]   = res_ovr;
        status[ST_SCANNING]  = (state != SC_IDLE);
        status[ST_PIPE_FULL] = pipe_full;
        status[ST_SL_EMPTY]  = sl_empty;
        status[ST_PACE_OVR]  = pace_ovr;
    end

    logic unused_cnt;
    assign unused_cnt = ^{sl_count, sl_full};

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R6
    AST_SCAN_NEEDS_PIPE: assert property (@(posedge clk) disable iff (rst)
        (state != SC_IDLE) |-> pipe_full); // R6
    AST_NO_START_UNLOADED: assert property (@(posedge clk) disable iff (rst)
        (state == SC_IDLE && !pipe_full) |=> (state != SC_ISSUE)); // R11
    AST_RES_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (res_ovr && !rst_res) |=> res_ovr); // R8
    AST_PACE_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pace_ovr && !rst_pipe) |=> pace_ovr); // R9

endmodule

// File: tb/acq_seq_bench.sv
module acq_seq_bench;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data, status;
    logic        conv_start, conv_settle, conv_hold;
    logic [4:0]  conv_sel;
    logic        adc_valid = 1'b0;
    logic [15:0] adc_data = '0;

    acq_seq u_acq_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .status(status),
        .conv_start(conv_start), .conv_sel(conv_sel), .conv_settle(conv_settle),
        .conv_hold(conv_hold), .adc_valid(adc_valid), .adc_data(adc_data)
    );

    always #5 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // converter model and request monitor
    int       adc_cd = 0;
    int       adc_n = 0;
    logic [4:0] pend_sel;
    int       mon_n = 0;
    logic [4:0] mon_sel [64];
    logic       mon_set [64];
    logic       mon_hld [64];
    int         mon_t   [64];

    always @(negedge clk) begin
        adc_valid = 1'b0;
        if (rst) begin
            adc_cd = 0;
        end else if (conv_start) begin
            adc_cd   = LAT;
            pend_sel = conv_sel;
            if (mon_n < 64) begin
                mon_sel[mon_n] = conv_sel;
                mon_set[mon_n] = conv_settle;
                mon_hld[mon_n] = conv_hold;
                mon_t[mon_n]   = cyc;
            end
            mon_n++;
        end else if (adc_cd > 0) begin
            adc_cd--;
            if (adc_cd == 0) begin
                adc_valid = 1'b1;
                adc_data  = {pend_sel, 3'b000, adc_n[7:0]};
                adc_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wsl(input logic [15:0] w);
        wr(2'd1, {24'h0, w[7:0]});
        wr(2'd1, {24'h0, w[15:8]});
    endtask

    task automatic put_desc(input logic [4:0] sel, input bit last, input bit st, input bit hd);
        wsl(16'h0000);
        wsl({12'h000, hd, last, st, 1'b0});
        wsl(16'h0800 | {8'h00, sel[1:0], 6'h00});
        wsl(16'hc000 | {13'h0, sel[4:2]});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_bit(input int b, input logic v, input int lim);
        for (int i = 0; i < lim; i++) begin
            if (status[b] == v) return;
            @(negedge clk);
        end
    endtask

    task automatic pop_check(input logic [15:0] exp, input string req);
        chk(rd_data == exp, req, rd_data, exp);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic logic [4:0] pick(input int nch, input int seed, input int k);
        return 5'((nch * 5 + k * 7 + seed * 11) & 31);
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(status == 16'h0020, "R1 status", status, 16'h0020);
        chk(conv_start == 1'b0, "R1 conv_start", conv_start, 0);

        // R2 R3 R6 R7 R10 sweep over channel counts and selection patterns
        for (int seed = 0; seed < 2; seed++) begin
            for (int nch = 1; nch <= 4; nch++) begin
                int base_adc, base_mon;
                wr(2'd0, 32'h0007);
                wr(2'd0, 32'h0010);
                for (int k = 0; k < nch; k++)
                    put_desc(pick(nch, seed, k), (k == nch - 1) && (nch < 4), k[0] ^ seed[0], k[1]);
                chk(status[5] == 1'b0 && status[4] == 1'b0, "R3 held while load off",
                    status, 16'h0000);
                wr(2'd0, 32'h0011);
                idle(24);
                chk(status == 16'h0030, "R3 pipe full after load", status, 16'h0030);
                wr(2'd0, 32'h0010);
                base_adc = adc_n;
                base_mon = mon_n;
                wr(2'd2, 32'd40);
                wr(2'd3, 32'd0);
                wr(2'd0, 32'h0031);
                wait_bit(3, 1'b1, 200);
                chk(status[3] == 1'b1, "R6 scanning flag", status, 16'h0008);
                wait_bit(3, 1'b0, 200);
                wr(2'd0, 32'h0030);
                chk(mon_n - base_mon == nch, "R6 requests per scan", mon_n - base_mon, nch);
                for (int k = 0; k < nch; k++) begin
                    chk(mon_sel[base_mon + k] == pick(nch, seed, k), "R2 R10 conv_sel order",
                        mon_sel[base_mon + k], pick(nch, seed, k));
                    chk(mon_set[base_mon + k] == (k[0] ^ seed[0]) && mon_hld[base_mon + k] == k[1],
                        "R10 flags", {mon_set[base_mon + k], mon_hld[base_mon + k]}, {k[0] ^ seed[0], k[1]});
                end
                chk(status[1] == 1'b1 && status[0] == (nch > 1), "R7 fill flags",
                    status[1:0], {1'b1, nch > 1});
                for (int k = 0; k < nch; k++)
                    pop_check({pick(nch, seed, k), 3'b000, 8'(base_adc + k)}, "R7 result order");
                chk(status[1:0] == 2'b00, "R7 drained", status[1:0], 0);
            end
        end

        // R4 scan-list reset realigns byte pairing
        wr(2'd0, 32'h0007);
        wr(2'd1, 32'h11); wr(2'd1, 32'h22); wr(2'd1, 32'h33);
        chk(status[5] == 1'b0, "R4 word pending", status[5], 0);
        wr(2'd0, 32'h0004);
        chk(status[5] == 1'b1, "R4 scan-list cleared", status[5], 1);
        begin
            int bm;
            put_desc(5'd9, 1'b1, 1'b0, 1'b0);
            wr(2'd0, 32'h0011); idle(24); wr(2'd0, 32'h0010);
            chk(status[4] == 1'b1, "R4 pipe loads after realign", status[4], 1);
            bm = mon_n;
            // R5 pacer period
            wr(2'd2, 32'd20); wr(2'd3, 32'd0); wr(2'd0, 32'h0031);
            for (int i = 0; i < 200 && mon_n < bm + 2; i++) @(negedge clk);
            wr(2'd0, 32'h0030);
            chk(mon_sel[bm] == 5'd9, "R4 realigned sel", mon_sel[bm], 9);
            chk(mon_t[bm + 1] - mon_t[bm] == 20, "R5 tick period", mon_t[bm + 1] - mon_t[bm], 20);
            // R5 high divider bits
            idle(20);
            bm = mon_n;
            wr(2'd2, 32'd5); wr(2'd3, 32'd1); wr(2'd0, 32'h0031);
            idle(150);
            wr(2'd0, 32'h0030);
            chk(mon_n == bm, "R5 high divider bits", mon_n - bm, 0);
            // R11 tick with empty pipe
            wr(2'd0, 32'h0007);
            bm = mon_n;
            wr(2'd2, 32'd4); wr(2'd3, 32'd0); wr(2'd0, 32'h0031);
            idle(60);
            wr(2'd0, 32'h0030);
            chk(mon_n == bm && status[3] == 1'b0, "R11 no scan when unloaded", mon_n - bm, 0);
        end

        // R8 R9 overrun through a short divider and a capacity-full pipe
        wr(2'd0, 32'h0007);
        for (int k = 0; k < 4; k++) put_desc(5'(k + 1), 1'b0, 1'b0, 1'b0);
        wr(2'd0, 32'h0011); idle(30); wr(2'd0, 32'h0010);
        chk(status[4] == 1'b1, "R3 full by capacity", status[4], 1);
        wr(2'd2, 32'd3); wr(2'd0, 32'h0031);
        idle(80);
        wr(2'd0, 32'h0030);
        idle(30);
        chk(status[8] == 1'b1, "R9 pacer overrun set", status[8], 1);
        chk(status[2] == 1'b1, "R8 results overrun set", status[2], 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); rd_en = 1'b1;
            @(negedge clk); rd_en = 1'b0;
        end
        chk(status[1] == 1'b0 && status[2] == 1'b1, "R8 overrun sticky after drain",
            status[2:1], 2'b10);
        wr(2'd0, 32'h0001);
        chk(status[8] == 1'b0 && status[4] == 1'b0, "R9 cleared by pipe reset", status, 16'h0024);
        chk(status[2] == 1'b1, "R8 survives pipe reset", status[2], 1);
        wr(2'd0, 32'h0002);
        chk(status[2] == 1'b0, "R8 cleared by results reset", status[2], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule